// File: doc/BRIEF.md
# Circular-buffer checksum engine

This block computes the 16-bit one's complement Internet checksum over an inclusive range of bytes held in an 8 KB packet buffer. The host loads a first-byte pointer, a last-byte pointer and a pair of bounds that define a circular receive region. It then writes the control register with both the run bit and the checksum-select bit set. The engine fetches one byte per clock through a read port with one cycle of latency. It pairs the bytes into big-endian words and adds each word into a 16-bit accumulator with end-around carry.

When the last byte has been folded in, the engine stores the complement of the sum as two result bytes, clears the run bit and sets a completion flag. The interrupt line follows that flag only while both the local and the global enable are set. The engine never writes the buffer or the pointer registers, so the host can read the result and compare it with a checksum carried in the packet.

Top module: `csum_dma`

## Requirements
- R1: Bytes are paired in fetch order into 16-bit words with the first byte of a pair as the high half. The words are summed with any carry out of bit 15 added back into bit 0, and the stored result is the bitwise complement of that sum. For example, bytes 89h ABh CDh give A953h.
- R2: When the range holds an odd number of bytes, the last byte forms the high half of a word whose low half is 00h.
- R3: One buffer byte is fetched per clock with no gaps. For a range of N bytes, the run bit reads 0 exactly N+1 clocks after the edge that accepts the start write, and rd_en is high for exactly N cycles.
- R4: After the address equal to the region's upper bound is fetched, the next fetch is at the region's lower bound. Otherwise the address steps by one modulo 8192. The range ends at the fetch of the last-byte pointer.
- R5: On completion, the run bit (CTRL bit 0) is cleared, the done flag (STAT bit 0) is set and the result is readable at SUM_L and SUM_H. A STAT write stores bit 0 and can clear the flag.
- R6: irq is high exactly when the done flag, the local enable (IEN bit 0) and the global enable (IEN bit 1) are all set.
- R7: A run leaves all pointer and bound registers unchanged. Writes to them, and to CTRL, are ignored while the run bit is set.
- R8: A CTRL write with bit 0 set but bit 1 (checksum select) clear starts nothing: the run bit stays 0, no byte is fetched and the flag is untouched.
- R9: After reset every register reads 0, irq is low and rd_en is low.
- R10: Register offsets are SRC_L 0h, SRC_H 1h, LST_L 2h, LST_H 3h, RGB_L 4h, RGB_H 5h, RGE_L 6h, RGE_H 7h, CTRL 8h, IEN 9h, STAT Ah, SUM_L Bh and SUM_H Ch. The high-pointer registers hold 5 bits, so writing FFh reads back 1Fh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset, for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| rd_en | output | 1 | Buffer read request |
| rd_addr | output | 13 | Buffer byte address |
| rd_data | input | 8 | Buffer byte, valid the cycle after rd_en |
| irq | output | 1 | Gated completion interrupt |

## Verification
The checksum is tried on even and odd lengths, on a single byte and on a 512-byte span. Together these separate the pairing and padding rules and confirm that the fetch stream has no gaps. Two ranges cross a wrap: one through the programmable region bounds and one through the top of the address space. A wrong wrap target makes them sum different bytes. The three-byte example pins down the end-around carry. Starting with the checksum select clear, and writing pointers during a run, show that both are ignored, while stepping the two enables separates the interrupt gating from the flag itself.

// File: rtl/csum_pkg.sv
package csum_pkg;
    localparam logic [3:0] RA_SRC_L = 4'h0;
    localparam logic [3:0] RA_SRC_H = 4'h1;
    localparam logic [3:0] RA_LST_L = 4'h2;
    localparam logic [3:0] RA_LST_H = 4'h3;
    localparam logic [3:0] RA_RGB_L = 4'h4;
    localparam logic [3:0] RA_RGB_H = 4'h5;
    localparam logic [3:0] RA_RGE_L = 4'h6;
    localparam logic [3:0] RA_RGE_H = 4'h7;
    localparam logic [3:0] RA_CTRL  = 4'h8;
    localparam logic [3:0] RA_IEN   = 4'h9;
    localparam logic [3:0] RA_STAT  = 4'hA;
    localparam logic [3:0] RA_SUM_L = 4'hB;
    localparam logic [3:0] RA_SUM_H = 4'hC;

    localparam int CTRL_RUN = 0;
    localparam int CTRL_SEL = 1;
    localparam int IEN_LOC  = 0;
    localparam int IEN_GLB  = 1;
endpackage

// File: rtl/csum_addr_walk.sv
module csum_addr_walk #(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] first_i,
    input  logic [AW-1:0] last_i,
    input  logic [AW-1:0] ring_lo_i,
    input  logic [AW-1:0] ring_hi_i,
    output logic          rd_en_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          final_o
);
    typedef struct packed {
        logic          act;
        logic [AW-1:0] addr;
    } walk_t;

    walk_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        rd_en_o   = s_q.act;
        rd_addr_o = s_q.addr;
        final_o   = s_q.act && (s_q.addr == last_i);
        if (load_i) begin
            s_d.act  = 1'b1;
            s_d.addr = first_i;
        end else if (s_q.act) begin
            if (final_o)
                s_d.act = 1'b0;
            else if (s_q.addr == ring_hi_i)
                s_d.addr = ring_lo_i;
            else
                s_d.addr = s_q.addr + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    a_r3_stride: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && $past(rd_en_o) && ($past(rd_addr_o) != $past(ring_hi_i)))
        |-> (rd_addr_o == $past(rd_addr_o) + AW'(1)));

    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && $past(rd_en_o) && ($past(rd_addr_o) == $past(ring_hi_i)))
        |-> (rd_addr_o == ring_lo_i));

    a_r4_stop_at_last: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && (rd_addr_o == last_i) && !load_i) |=> !rd_en_o);
endmodule

// File: rtl/csum_fold_acc.sv
module csum_fold_acc #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear_i,
    input  logic           take_i,
    input  logic           last_i,
    input  logic [W/2-1:0] byte_i,
    output logic           done_o,
    output logic [W-1:0]   sum_o
);
    localparam int BW = W / 2;

    typedef struct packed {
        logic          vld;
        logic          lst;
        logic          odd;
        logic [BW-1:0] hi;
        logic [W-1:0]  acc;
    } acc_t;

    acc_t        s_d, s_q;
    logic [W-1:0] word;
    logic [W:0]   wide;
    logic [W-1:0] folded;

    always_comb begin
        s_d    = s_q;
        s_d.vld = take_i;
        s_d.lst = last_i;
        word   = s_q.odd ? {s_q.hi, byte_i} : {byte_i, BW'(0)};
        wide   = {1'b0, s_q.acc} + {1'b0, word};
        folded = wide[W-1:0] + W'(wide[W]);
        done_o = s_q.vld && s_q.lst;
        sum_o  = (s_q.vld && (s_q.odd || s_q.lst)) ? folded : s_q.acc;
        if (clear_i) begin
            s_d.acc = '0;
            s_d.odd = 1'b0;
            s_d.hi  = '0;
        end else if (s_q.vld) begin
            if (s_q.lst) begin
                s_d.acc = folded;
                s_d.odd = 1'b0;
            end else if (s_q.odd) begin
                s_d.acc = folded;
                s_d.odd = 1'b0;
            end else begin
                s_d.hi  = byte_i;
                s_d.odd = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.vld && !clear_i) |=> $stable(s_q.acc));

    a_r2_pair_reset: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !s_q.odd);
endmodule

// File: rtl/csum_dma.sv
module csum_dma #(
    parameter int AW = 13,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [3:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic          irq
);
    import csum_pkg::*;

    localparam int HW = AW - 8;

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] lst;
        logic [AW-1:0] rgb;
        logic [AW-1:0] rge;
        logic          run;
        logic          sel;
        logic          loc;
        logic          glb;
        logic          flag;
        logic [SW-1:0] res;
    } top_t;

    top_t         s_d, s_q;
    logic         idle_wr;
    logic         fire;
    logic         fin;
    logic         done;
    logic [SW-1:0] sum;

    csum_addr_walk #(.AW(AW)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (fire),
        .first_i   (s_q.src),
        .last_i    (s_q.lst),
        .ring_lo_i (s_q.rgb),
        .ring_hi_i (s_q.rge),
        .rd_en_o   (rd_en),
        .rd_addr_o (rd_addr),
        .final_o   (fin)
    );

    csum_fold_acc #(.W(SW)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (fire),
        .take_i  (rd_en),
        .last_i  (fin),
        .byte_i  (rd_data),
        .done_o  (done),
        .sum_o   (sum)
    );

    always_comb begin
        s_d     = s_q;
        idle_wr = reg_wr && !s_q.run;
        fire    = idle_wr && (reg_addr == RA_CTRL)
                  && reg_wdata[CTRL_RUN] && reg_wdata[CTRL_SEL];
        if (idle_wr) begin
            case (reg_addr)
                RA_SRC_L: s_d.src[7:0]    = reg_wdata;
                RA_SRC_H: s_d.src[AW-1:8] = reg_wdata[HW-1:0];
                RA_LST_L: s_d.lst[7:0]    = reg_wdata;
                RA_LST_H: s_d.lst[AW-1:8] = reg_wdata[HW-1:0];
                RA_RGB_L: s_d.rgb[7:0]    = reg_wdata;
                RA_RGB_H: s_d.rgb[AW-1:8] = reg_wdata[HW-1:0];
                RA_RGE_L: s_d.rge[7:0]    = reg_wdata;
                RA_RGE_H: s_d.rge[AW-1:8] = reg_wdata[HW-1:0];
                RA_CTRL: begin
                    s_d.sel = reg_wdata[CTRL_SEL];
                    s_d.run = fire;
                end
                default: ;
            endcase
        end
        if (reg_wr && reg_addr == RA_IEN) begin
            s_d.loc = reg_wdata[IEN_LOC];
            s_d.glb = reg_wdata[IEN_GLB];
        end
        if (reg_wr && reg_addr == RA_STAT)
            s_d.flag = reg_wdata[0];
        if (done) begin
            s_d.run  = 1'b0;
            s_d.flag = 1'b1;
            s_d.res  = ~sum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq = s_q.flag && s_q.loc && s_q.glb;

    always_comb begin
        case (reg_addr)
            RA_SRC_L: reg_rdata = s_q.src[7:0];
            RA_SRC_H: reg_rdata = 8'(s_q.src[AW-1:8]);
            RA_LST_L: reg_rdata = s_q.lst[7:0];
            RA_LST_H: reg_rdata = 8'(s_q.lst[AW-1:8]);
            RA_RGB_L: reg_rdata = s_q.rgb[7:0];
            RA_RGB_H: reg_rdata = 8'(s_q.rgb[AW-1:8]);
            RA_RGE_L: reg_rdata = s_q.rge[7:0];
            RA_RGE_H: reg_rdata = 8'(s_q.rge[AW-1:8]);
            RA_CTRL:  reg_rdata = {6'b0, s_q.sel, s_q.run};
            RA_IEN:   reg_rdata = {6'b0, s_q.glb, s_q.loc};
            RA_STAT:  reg_rdata = {7'b0, s_q.flag};
            RA_SUM_L: reg_rdata = s_q.res[7:0];
            RA_SUM_H: reg_rdata = s_q.res[SW-1:8];
            default:  reg_rdata = 8'h00;
        endcase
    end

    a_r8_no_fetch_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.run |-> !rd_en);

    a_r5_flag_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.run) |-> s_q.flag);

    a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && $past(s_q.run)) |-> ($stable(s_q.src) && $stable(s_q.lst)
                                          && $stable(s_q.rgb) && $stable(s_q.rge)));

    a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.flag |-> !irq);
endmodule

// File: tb/csum_dma_tb.sv
module csum_dma_tb;
    localparam int CLK_NS = 10;
    localparam int NVEC = 6;
    // {first, last, ring_lo, ring_hi}
    localparam logic [51:0] VEC [NVEC] = '{
        {13'h0010, 13'h0011, 13'h1000, 13'h1FFF},
        {13'h0020, 13'h0024, 13'h1000, 13'h1FFF},
        {13'h0000, 13'h0000, 13'h1000, 13'h1FFF},
        {13'h00F0, 13'h0008, 13'h0000, 13'h00FF},
        {13'h1FFC, 13'h0003, 13'h0000, 13'h1FFF},
        {13'h0200, 13'h03FF, 13'h1000, 13'h1FFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        rd_en;
    logic [12:0] rd_addr;
    logic [7:0]  rd_data;
    logic        irq;
    logic [7:0]  mem [0:8191];
    int          checks = 0;
    int          errors = 0;
    int          fetches = 0;

    always #(CLK_NS/2) clk = ~clk;

    csum_dma u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    always @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem[rd_addr];
            fetches <= fetches + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic model(input logic [12:0] s, e, rb, re,
                         output logic [15:0] cs, output int n);
        logic [12:0] a;
        logic [31:0] acc;
        logic [7:0]  hi;
        bit          odd;
        a = s; acc = 0; n = 0; odd = 0; hi = 0;
        forever begin
            if (!odd) begin hi = mem[a]; odd = 1; end
            else begin acc = acc + {16'h0, hi, mem[a]}; odd = 0; end
            n++;
            if (a == e || n > 9000) break;
            a = (a == re) ? rb : a + 13'd1;
        end
        if (odd) acc = acc + {16'h0, hi, 8'h00};
        while (acc[31:16] != 0) acc = {16'h0, acc[15:0]} + {16'h0, acc[31:16]};
        cs = ~acc[15:0];
    endtask

    task automatic setp(input logic [12:0] s, e, rb, re);
        wr(4'h0, s[7:0]);  wr(4'h1, {3'b0, s[12:8]});
        wr(4'h2, e[7:0]);  wr(4'h3, {3'b0, e[12:8]});
        wr(4'h4, rb[7:0]); wr(4'h5, {3'b0, rb[12:8]});
        wr(4'h6, re[7:0]); wr(4'h7, {3'b0, re[12:8]});
    endtask

    task automatic wait_done(output int cyc);
        logic [7:0] c;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            rd(4'h8, c);
        end while (c[0] && cyc < 20000);
    endtask

    task automatic get_sum(output logic [15:0] v);
        logic [7:0] l, h;
        rd(4'hB, l); rd(4'hC, h);
        v = {h, l};
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] got, exp;
        int          n, cyc, f0;
        for (int i = 0; i < 8192; i++) mem[i] = 8'((i * 29 + 7) ^ (i >> 5));
        repeat (3) @(negedge clk);
        // R9: reset state
        for (int a = 0; a < 13; a++) begin
            rd(4'(a), d);
            check(d == 8'h00, "R9 reset reg", d, 0);
        end
        check(irq == 1'b0 && rd_en == 1'b0, "R9 reset outputs", {irq, rd_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(reg_rdata == 8'h00 && irq == 1'b0, "R9 after release", reg_rdata, 0);

        // R10: high pointer holds 5 bits
        wr(4'h1, 8'hFF); rd(4'h1, d);
        check(d == 8'h1F, "R10 high pointer width", d, 8'h1F);

        // R1/R2: three-byte example
        mem[100] = 8'h89; mem[101] = 8'hAB; mem[102] = 8'hCD;
        setp(13'd100, 13'd102, 13'h1000, 13'h1FFF);
        wr(4'h8, 8'h03); wait_done(cyc); get_sum(got);
        check(got == 16'hA953, "R1 R2 example checksum", got, 16'hA953);

        // vector table: R1 R2 R3 R4 R5 R7
        for (int v = 0; v < NVEC; v++) begin
            logic [12:0] s, e, rb, re;
            {s, e, rb, re} = VEC[v];
            model(s, e, rb, re, exp, n);
            setp(s, e, rb, re);
            wr(4'hA, 8'h00);
            f0 = fetches;
            wr(4'h8, 8'h03);
            wait_done(cyc);
            get_sum(got);
            check(got == exp, "R1 R2 R4 vector checksum", got, exp);
            check(cyc == n + 1, "R3 run length", cyc, n + 1);
            check(fetches - f0 == n, "R3 fetch count", fetches - f0, n);
            rd(4'hA, d);
            check(d == 8'h01, "R5 done flag", d, 1);
            rd(4'h0, d);
            check(d == s[7:0], "R7 first ptr kept", d, s[7:0]);
            rd(4'h7, d);
            check(d == 8'(re[12:8]), "R7 ring bound kept", d, re[12:8]);
        end

        // R7: pointer writes during a run are ignored
        setp(13'h0200, 13'h03FF, 13'h1000, 13'h1FFF);
        wr(4'h8, 8'h03);
        wr(4'h0, 8'h55);
        wr(4'h6, 8'h12);
        wait_done(cyc);
        rd(4'h0, d);
        check(d == 8'h00, "R7 busy write to first ptr", d, 0);
        rd(4'h6, d);
        check(d == 8'hFF, "R7 busy write to ring bound", d, 8'hFF);

        // R8: start without checksum select
        wr(4'hA, 8'h00);
        f0 = fetches;
        wr(4'h8, 8'h01);
        repeat (4) @(negedge clk);
        rd(4'h8, d);
        check(d == 8'h00, "R8 run bit stays clear", d, 0);
        check(fetches == f0, "R8 no fetch", fetches - f0, 0);
        rd(4'hA, d);
        check(d == 8'h00, "R8 flag untouched", d, 0);

        // R6: interrupt gating
        wr(4'h9, 8'h03);
        #1 check(irq == 1'b0, "R6 no flag no irq", irq, 0);
        setp(13'd100, 13'd102, 13'h1000, 13'h1FFF);
        wr(4'h9, 8'h01);
        wr(4'h8, 8'h03); wait_done(cyc);
        #1 check(irq == 1'b0, "R6 global enable off", irq, 0);
        wr(4'h9, 8'h02);
        #1 check(irq == 1'b0, "R6 local enable off", irq, 0);
        wr(4'h9, 8'h03);
        #1 check(irq == 1'b1, "R6 both enables", irq, 1);
        wr(4'hA, 8'h00);
        #1 check(irq == 1'b0, "R5 R6 flag cleared", irq, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule